// File: doc/BRIEF.md
# I2C Byte Transfer Sequencer

This block turns one software command into a complete byte-level I2C exchange. A command carries five flags (generate START, generate STOP, read a byte, write a byte, and the acknowledge level to drive after a read) together with a transmit byte. The block sends a series of single-bit operations to a bit-level timing engine, which is outside this block. Each operation uses a hold-until-acknowledge handshake. The sequence is an optional START, eight data bits, one acknowledge bit and an optional STOP.

Data moves through one shift register, most significant bit first. The transmit byte is loaded into it when the command is accepted. Each bit that returns from the bus is shifted in, so after a read the register holds the received byte. The block reports three things to the register layer: a busy flag covering the whole sequence, a one-clock completion strobe that can feed an interrupt, and the acknowledge seen from the slave. If the bit engine reports lost arbitration, the sequence is cut short and a sticky flag is raised.

Top module: `i2c_byte_ctrl`

## Requirements
- R1: After reset, busy_o, done_o and arb_lost_o are 0 and bit_cmd_o is NOP. The bit operation codes are NOP=0, START=1, STOP=2, WRITE=3 and READ=4.
- R2: A go_i pulse is accepted only while the block is idle and at least one of the START, STOP, READ and WRITE flags is set. An accepted command issues its operations in the order START, data bits, acknowledge bit, STOP, and each phase appears only when its flag was set. A go_i that is not accepted issues no operation and changes nothing.
- R3: A write issues eight WRITE operations. Their bit_din_o values are tx_byte_i as it was at acceptance, most significant bit first.
- R4: A read issues eight READ operations with bit_din_o=1. The returned bits are shifted into rx_byte_o, most significant bit first.
- R5: After the eight bits of a read, the block issues one WRITE operation whose bit_din_o equals ack_val_i as captured at acceptance (0 means ACK).
- R6: After the eight bits of a write, the block issues one READ operation. rx_nack_o takes the returned bit, so 1 means no slave pulled SDA low.
- R7: busy_o rises in the cycle after acceptance and falls in the cycle after the last operation is acknowledged. This also holds for a command that requests only a STOP.
- R8: bit_cmd_o and bit_din_o stay unchanged until bit_ack_i. Each acknowledge completes exactly one operation.
- R9: When bit_al_i arrives during a transfer, the block is idle in the next cycle with bit_cmd_o=NOP and issues no further operations. arb_lost_o is set and stays set until the next accepted command.
- R10: done_o pulses for one clock when a sequence completes or is aborted. The latched flags are then cleared, so no operation follows without a new go_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Command strobe |
| req_start_i | input | 1 | Generate START or repeated START first |
| req_stop_i | input | 1 | Generate STOP last |
| req_read_i | input | 1 | Read one byte |
| req_write_i | input | 1 | Write one byte |
| ack_val_i | input | 1 | Acknowledge level driven after a read |
| tx_byte_i | input | DATA_W | Byte to transmit |
| rx_byte_o | output | DATA_W | Shift register contents / received byte |
| rx_nack_o | output | 1 | Slave acknowledge after a write, 1 = NACK |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-clock completion strobe |
| arb_lost_o | output | 1 | Sticky arbitration-lost flag |
| bit_cmd_o | output | 3 | Bit operation to the bit engine |
| bit_din_o | output | 1 | Bit value for a WRITE operation |
| bit_ack_i | input | 1 | Bit engine finished the current operation |
| bit_al_i | input | 1 | Bit engine lost arbitration |
| bit_dout_i | input | 1 | Bit sampled from the bus |

## Verification
The bench builds the block with DATA_W=8, which is a real I2C byte, so the full eight-bit shift sequence and the wrap of the bit counter into the acknowledge phase are exercised exactly. The bench's bit-engine model has a latency that can be adjusted. Raising it holds every operation pending for several cycles, which exposes any early change of the command. Its arbitration-loss injection can be placed at any operation index, so an abort can be tested in the middle of the data bits.

// File: rtl/i2c_xfer_pkg.sv
package i2c_xfer_pkg;

  typedef enum logic [2:0] {
    BIT_NOP   = 3'd0,
    BIT_START = 3'd1,
    BIT_STOP  = 3'd2,
    BIT_WRITE = 3'd3,
    BIT_READ  = 3'd4
  } bit_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_ACK,
    S_STOP
  } seq_st_e;

  typedef struct packed {
    logic sta;
    logic sto;
    logic rd;
    logic wr;
    logic ackv;
  } req_t;

endpackage

// File: rtl/i2c_byte_shreg.sv
module i2c_byte_shreg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  input  logic         shift_i,
  input  logic         sin_i,
  output logic [W-1:0] q_o,
  output logic         msb_o
);

  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= '0;
    else if (load_i)  q_q <= d_i;
    else if (shift_i) q_q <= {q_q[W-2:0], sin_i};
  end

  assign q_o   = q_q;
  assign msb_o = q_q[W-1];

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q_q == $past(d_i));

endmodule

// File: rtl/i2c_bit_cnt.sv
module i2c_bit_cnt #(
  parameter int W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST);

endmodule

// File: rtl/i2c_byte_seq.sv
module i2c_byte_seq
  import i2c_xfer_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    go_i,
  input  req_t    req_i,
  input  logic    bit_ack_i,
  input  logic    bit_al_i,
  input  logic    bit_dout_i,
  input  logic    msb_i,
  input  logic    last_i,
  output bit_op_e bit_cmd_o,
  output logic    bit_din_o,
  output logic    load_o,
  output logic    shift_o,
  output logic    cnt_clr_o,
  output logic    cnt_inc_o,
  output logic    busy_o,
  output logic    done_o,
  output logic    arb_lost_o,
  output logic    rx_nack_o
);

  seq_st_e state_q, state_d;
  req_t    req_q, req_d;
  logic    fin, abort, nack_upd, accept, has_data;
  logic    done_q, arb_q, nack_q;

  assign accept   = go_i && (state_q == S_IDLE) &&
                    (req_i.sta || req_i.sto || req_i.rd || req_i.wr);
  assign has_data = req_q.rd || req_q.wr;

  always_comb begin
    state_d   = state_q;
    req_d     = req_q;
    fin       = 1'b0;
    abort     = 1'b0;
    nack_upd  = 1'b0;
    load_o    = 1'b0;
    shift_o   = 1'b0;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    unique case (state_q)
      S_IDLE: if (accept) begin
        req_d     = req_i;
        load_o    = 1'b1;
        cnt_clr_o = 1'b1;
        if (req_i.sta)                 state_d = S_START;
        else if (req_i.rd || req_i.wr) state_d = S_DATA;
        else                           state_d = S_STOP;
      end
      S_START: if (bit_ack_i) begin
        if (has_data)       state_d = S_DATA;
        else if (req_q.sto) state_d = S_STOP;
        else begin
          state_d = S_IDLE;
          fin     = 1'b1;
        end
      end
      S_DATA: if (bit_ack_i) begin
        shift_o   = 1'b1;
        cnt_inc_o = 1'b1;
        if (last_i) state_d = S_ACK;
      end
      S_ACK: if (bit_ack_i) begin
        nack_upd = req_q.wr;
        if (req_q.sto) state_d = S_STOP;
        else begin
          state_d = S_IDLE;
          fin     = 1'b1;
        end
      end
      S_STOP: if (bit_ack_i) begin
        state_d = S_IDLE;
        fin     = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
    // arbitration loss overrides any progress this cycle
    if (state_q != S_IDLE && bit_al_i) begin
      state_d   = S_IDLE;
      fin       = 1'b1;
      abort     = 1'b1;
      shift_o   = 1'b0;
      cnt_inc_o = 1'b0;
      nack_upd  = 1'b0;
    end
    if (fin) req_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      req_q   <= '0;
      done_q  <= 1'b0;
      arb_q   <= 1'b0;
      nack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      done_q  <= fin;
      if (accept)     arb_q <= 1'b0;
      else if (abort) arb_q <= 1'b1;
      if (nack_upd)   nack_q <= bit_dout_i;
    end
  end

  always_comb begin
    bit_cmd_o = BIT_NOP;
    bit_din_o = 1'b1;
    unique case (state_q)
      S_START: bit_cmd_o = BIT_START;
      S_DATA: begin
        bit_cmd_o = req_q.wr ? BIT_WRITE : BIT_READ;
        bit_din_o = req_q.wr ? msb_i : 1'b1;
      end
      S_ACK: begin
        bit_cmd_o = req_q.wr ? BIT_READ : BIT_WRITE;
        bit_din_o = req_q.wr ? 1'b1 : req_q.ackv;
      end
      S_STOP:  bit_cmd_o = BIT_STOP;
      default: bit_cmd_o = BIT_NOP;
    endcase
  end

  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = done_q;
  assign arb_lost_o = arb_q;
  assign rx_nack_o  = nack_q;

  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && !busy_o && (req_i.sta || req_i.sto || req_i.rd || req_i.wr)) |=> busy_o);

  p_stop_last_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_cmd_o == BIT_STOP && bit_ack_i && !bit_al_i) |=> (!busy_o && done_o));

  p_hold_cmd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !bit_ack_i && !bit_al_i) |=> ($stable(bit_cmd_o) && $stable(bit_din_o)));

  p_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && bit_al_i) |=> (!busy_o && arb_lost_o && bit_cmd_o == BIT_NOP));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

// File: rtl/i2c_byte_ctrl.sv
module i2c_byte_ctrl
  import i2c_xfer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              req_start_i,
  input  logic              req_stop_i,
  input  logic              req_read_i,
  input  logic              req_write_i,
  input  logic              ack_val_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_nack_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              arb_lost_o,
  output logic [2:0]        bit_cmd_o,
  output logic              bit_din_o,
  input  logic              bit_ack_i,
  input  logic              bit_al_i,
  input  logic              bit_dout_i
);

  req_t    req;
  bit_op_e cmd;
  logic    load, shift, cnt_clr, cnt_inc, last, msb;

  assign req = '{sta: req_start_i, sto: req_stop_i, rd: req_read_i,
                 wr: req_write_i, ackv: ack_val_i};

  i2c_byte_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (go_i),
    .req_i      (req),
    .bit_ack_i  (bit_ack_i),
    .bit_al_i   (bit_al_i),
    .bit_dout_i (bit_dout_i),
    .msb_i      (msb),
    .last_i     (last),
    .bit_cmd_o  (cmd),
    .bit_din_o  (bit_din_o),
    .load_o     (load),
    .shift_o    (shift),
    .cnt_clr_o  (cnt_clr),
    .cnt_inc_o  (cnt_inc),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .arb_lost_o (arb_lost_o),
    .rx_nack_o  (rx_nack_o)
  );

  i2c_byte_shreg #(.W(DATA_W)) u_shreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .d_i     (tx_byte_i),
    .shift_i (shift),
    .sin_i   (bit_dout_i),
    .q_o     (rx_byte_o),
    .msb_o   (msb)
  );

  i2c_bit_cnt #(.W(DATA_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .last_o (last)
  );

  assign bit_cmd_o = cmd;

endmodule

// File: tb/i2c_byte_ctrl_tb_top.sv
module i2c_byte_ctrl_tb_top;

  localparam int CMD_NOP = 0, CMD_START = 1, CMD_STOP = 2, CMD_WRITE = 3, CMD_READ = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       go = 1'b0, r_sta = 1'b0, r_sto = 1'b0, r_rd = 1'b0, r_wr = 1'b0, r_ackv = 1'b0;
  logic [7:0] tx = '0;
  logic [7:0] rx_byte;
  logic       rx_nack, busy, done, arb_lost, bit_din;
  logic [2:0] bit_cmd;
  logic       bit_ack = 1'b0, bit_al = 1'b0, bit_dout = 1'b0;

  int         n_chk = 0, n_fail = 0;
  int         lat = 2;
  logic [7:0] slave_byte = '0;
  logic       slave_ack = 1'b0;
  int         data_n = 0, op_n = 0, al_at = -1, log_n = 0, done_cnt = 0, hold_err = 0, wcnt = 0;
  logic [2:0] cmd_log [32];
  logic       din_log [32];
  logic [2:0] prev_cmd = '0;
  logic       prev_din = 1'b0;

  always #4 clk = ~clk;

  i2c_byte_ctrl #(.DATA_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .go_i(go),
    .req_start_i(r_sta), .req_stop_i(r_sto), .req_read_i(r_rd), .req_write_i(r_wr),
    .ack_val_i(r_ackv), .tx_byte_i(tx), .rx_byte_o(rx_byte), .rx_nack_o(rx_nack),
    .busy_o(busy), .done_o(done), .arb_lost_o(arb_lost),
    .bit_cmd_o(bit_cmd), .bit_din_o(bit_din),
    .bit_ack_i(bit_ack), .bit_al_i(bit_al), .bit_dout_i(bit_dout)
  );

  // bit engine model
  always @(negedge clk) begin
    if (!rst_n) begin
      bit_ack = 1'b0; bit_al = 1'b0; wcnt = 0;
    end else begin
      if (done) done_cnt++;
      if (bit_ack || bit_al) begin
        bit_ack = 1'b0; bit_al = 1'b0; wcnt = 0;
      end else if (bit_cmd != 3'(CMD_NOP)) begin
        if (wcnt > 0 && (bit_cmd != prev_cmd || bit_din != prev_din)) hold_err++;
        prev_cmd = bit_cmd; prev_din = bit_din;
        wcnt++;
        if (wcnt >= lat) begin
          if (op_n == al_at) bit_al = 1'b1;
          else begin
            if (log_n < 32) begin
              cmd_log[log_n] = bit_cmd; din_log[log_n] = bit_din;
            end
            log_n++;
            if (bit_cmd == 3'(CMD_READ))
              bit_dout = (data_n < 8) ? slave_byte[7 - data_n] : slave_ack;
            else if (bit_cmd == 3'(CMD_WRITE)) bit_dout = bit_din;
            else bit_dout = 1'b1;
            if (bit_cmd == 3'(CMD_READ) || bit_cmd == 3'(CMD_WRITE)) data_n++;
            bit_ack = 1'b1;
          end
          op_n++;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr_log();
    log_n = 0; op_n = 0; data_n = 0; done_cnt = 0; al_at = -1; hold_err = 0;
  endtask

  task automatic issue(input logic sta, sto, rd, wr, ackv, input logic [7:0] b);
    @(negedge clk);
    r_sta = sta; r_sto = sto; r_rd = rd; r_wr = wr; r_ackv = ackv; tx = b; go = 1'b1;
    @(negedge clk);
    go = 1'b0; r_sta = 1'b0; r_sto = 1'b0; r_rd = 1'b0; r_wr = 1'b0; r_ackv = 1'b0; tx = 8'h00;
  endtask

  task automatic wait_idle();
    int k = 0;
    while (busy && k < 2000) begin
      @(negedge clk); k++;
    end
    if (busy) chk("R7 timeout waiting for idle", 1, 0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy after reset", busy, 0);
    chk("R1 done after reset", done, 0);
    chk("R1 arb_lost after reset", arb_lost, 0);
    chk("R1 bit_cmd NOP after reset", bit_cmd, CMD_NOP);
  endtask

  task automatic t_write_full();
    clr_log(); slave_ack = 1'b0;
    issue(1, 1, 0, 1, 0, 8'hA5);
    chk("R7 busy after accept", busy, 1);
    wait_idle();
    chk("R2 op count start+write+ack+stop", log_n, 11);
    chk("R2 first op START", cmd_log[0], CMD_START);
    for (int i = 0; i < 8; i++) begin
      chk("R3 data op WRITE", cmd_log[1+i], CMD_WRITE);
      chk("R3 data bit MSB first", din_log[1+i], 8'hA5 >> (7 - i) & 1);
    end
    chk("R6 ack op READ", cmd_log[9], CMD_READ);
    chk("R2 last op STOP", cmd_log[10], CMD_STOP);
    chk("R6 slave ACK seen", rx_nack, 0);
    chk("R10 single done", done_cnt, 1);
    chk("R8 no change while pending", hold_err, 0);
  endtask

  task automatic t_no_slave();
    clr_log(); slave_ack = 1'b1;
    issue(0, 0, 0, 1, 0, 8'h3E);
    wait_idle();
    chk("R6 op count write only", log_n, 9);
    chk("R6 NACK reported", rx_nack, 1);
    slave_ack = 1'b0;
  endtask

  task automatic t_read(input logic [7:0] sb, input logic av, input logic sto);
    clr_log(); slave_byte = sb;
    issue(0, sto, 1, 0, av, 8'h00);
    wait_idle();
    chk("R4 op count read", log_n, sto ? 10 : 9);
    for (int i = 0; i < 8; i++) begin
      chk("R4 data op READ", cmd_log[i], CMD_READ);
      chk("R4 read din released", din_log[i], 1);
    end
    chk("R5 ack op WRITE", cmd_log[8], CMD_WRITE);
    chk("R5 ack level", din_log[8], av);
    if (sto) chk("R2 read then STOP", cmd_log[9], CMD_STOP);
    chk("R4 received byte", rx_byte, sb);
  endtask

  task automatic t_stop_only();
    clr_log();
    issue(0, 1, 0, 0, 0, 8'h00);
    chk("R7 busy for standalone STOP", busy, 1);
    wait_idle();
    chk("R7 one op", log_n, 1);
    chk("R7 op is STOP", cmd_log[0], CMD_STOP);
    chk("R10 done for STOP", done_cnt, 1);
  endtask

  task automatic t_start_only();
    clr_log();
    issue(1, 0, 0, 0, 0, 8'h00);
    wait_idle();
    chk("R2 repeated START alone", log_n, 1);
    chk("R2 op is START", cmd_log[0], CMD_START);
  endtask

  task automatic t_busy_ignore();
    clr_log(); slave_ack = 1'b0;
    issue(1, 0, 0, 1, 0, 8'h5A);
    repeat (6) @(negedge clk);
    issue(0, 1, 1, 0, 1, 8'hFF);
    wait_idle();
    repeat (10) @(negedge clk);
    chk("R2 go while busy ignored", log_n, 10);
    chk("R10 no op after done", bit_cmd, CMD_NOP);
    chk("R10 done count", done_cnt, 1);
  endtask

  task automatic t_noflag();
    clr_log();
    issue(0, 0, 0, 0, 1, 8'hFF);
    chk("R2 flagless go not accepted", busy, 0);
    repeat (10) @(negedge clk);
    chk("R2 flagless go issues nothing", log_n, 0);
    chk("R10 flagless go no done", done_cnt, 0);
  endtask

  task automatic t_slow_engine();
    lat = 6;
    t_read(8'h96, 1'b0, 1'b1);
    chk("R8 held during long wait", hold_err, 0);
    lat = 2;
  endtask

  task automatic t_arb();
    clr_log(); al_at = 3;
    issue(1, 1, 0, 1, 0, 8'hF0);
    wait_idle();
    repeat (10) @(negedge clk);
    chk("R9 arb_lost set", arb_lost, 1);
    chk("R9 no ops after loss", log_n, 3);
    chk("R9 bit_cmd NOP", bit_cmd, CMD_NOP);
    chk("R10 done on abort", done_cnt, 1);
    clr_log();
    issue(0, 1, 0, 0, 0, 8'h00);
    chk("R9 arb_lost cleared on accept", arb_lost, 0);
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_full();
    t_no_slave();
    t_read(8'h3C, 1'b1, 1'b1);
    t_read(8'hC3, 1'b0, 1'b0);
    t_stop_only();
    t_start_only();
    t_busy_ignore();
    t_noflag();
    t_slow_engine();
    t_arb();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule